// File: doc/BRIEF.md
# DRAM Row Cycle Classifier with Self-Refresh Row Counter

This block sits inside a dynamic memory device, between the row and column strobe pins and the row decoder. Each time the active-low row strobe `ras_n` falls, it decides what kind of cycle begins. If the column strobe `cas_n` is already low at that moment, the cycle is a counter-driven refresh: the row comes from an internal counter and the address pins are not looked at. Otherwise the cycle is an ordinary row cycle: the row is latched from the address pins. That row is opened whether the access then turns out to be RAS-only, a read, a write or a read-modify-write.

The strobes are sampled on a fast on-chip clock through a short synchronizer, and their edges are detected from the synchronized levels. The block raises `row_active` for as long as the row strobe is low, presents the chosen row on `row_addr`, and flags the kind of cycle on `cycle_cbr`. The internal counter steps forward by one when a counter-driven refresh ends, so successive refresh cycles sweep every row in turn. A cycle is only over once both strobes have returned high, in either order.

Top module: `dram_cbr_refresh`

## Requirements
- R1: After reset, `row_active` is 0, `cycle_cbr` is 0, `row_addr` is 0, and the internal refresh counter holds 0, so the first counter-driven refresh opens row 0.
- R2: When `cas_n` is low at the `ras_n` fall, `cycle_cbr` becomes 1 and `row_addr` takes the internal counter value, whatever is on `addr`.
- R3: When `cas_n` is high at the `ras_n` fall, `cycle_cbr` becomes 0 and `row_addr` takes the value on `addr`.
- R4: The counter grows by one at the `ras_n` rise that ends each counter-driven refresh, so the next such refresh opens the next row.
- R5: The counter wraps from 511 to 0 (9-bit counter).
- R6: Ordinary row cycles (RAS-only, read, write) leave the counter unchanged.
- R7: `row_active` rises on the third rising clock edge after `ras_n` falls, and falls on the third rising edge after `ras_n` rises. It is not yet set after two edges.
- R8: While `row_active` is 1, `cycle_cbr` and `row_addr` hold steady, even if `addr` changes.
- R9: A cycle ends only when both strobes are high. A `ras_n` fall that comes while `cas_n` is still low from the previous cycle opens no row and does not advance the counter.
- R10: A `cas_n` fall during an ordinary row cycle (a read or write access) does not turn it into a refresh. `cycle_cbr` stays 0 and the row stays put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the strobe timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| addr | input | 9 | External row address pins |
| row_active | output | 1 | High while a row is open |
| row_addr | output | 9 | Row selected for the current cycle |
| cycle_cbr | output | 1 | 1 when the current cycle is a counter-driven refresh |

## Verification
Each strobe passes through two synchronizer flops and one output register. A change in `ras_n` therefore shows on `row_active`, `cycle_cbr` and `row_addr` on the third rising edge after it, and a counter step made at a `ras_n` rise first shows in the row of the next refresh. The bench changes its inputs on falling clock edges. It samples on the falling edge that follows the third rising edge, and it also samples one edge earlier to confirm that the output has not yet moved. Before every strobe edge it leaves at least three cycles, so that the other strobe's synchronized level has settled when the decision is made.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } cyc_state_e;

  localparam int STB_COUNT = 2;
  localparam int STB_RAS   = 0;
  localparam int STB_CAS   = 1;
endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
      prev_q  <= RESET_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[LAST];
    end
  end

  assign lvl  = chain_q[LAST];
  assign fall = prev_q & ~chain_q[LAST];
  assign rise = ~prev_q & chain_q[LAST];
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] cnt
);
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  function automatic logic [ROW_W-1:0] next_refresh_row(input logic [ROW_W-1:0] r);
    if (r == ROW_LAST) return '0;
    return ROW_W'(r + 1'b1);
  endfunction

  logic [ROW_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= next_refresh_row(cnt_q);
  end

  assign cnt = cnt_q;

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q == ROW_LAST) |=> (cnt_q == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/row_cycle_classifier.sv
module row_cycle_classifier
  import dram_rfsh_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_lvl,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_lvl,
  input  logic [ROW_W-1:0] ext_row,
  input  logic [ROW_W-1:0] ref_row,
  output logic             row_active,
  output logic             cycle_cbr,
  output logic [ROW_W-1:0] row_addr,
  output logic             inc_req
);
  function automatic logic [ROW_W-1:0] pick_row(input logic cbr,
                                               input logic [ROW_W-1:0] cnt_row,
                                               input logic [ROW_W-1:0] pin_row);
    return cbr ? cnt_row : pin_row;
  endfunction

  cyc_state_e       state_q, state_d;
  logic             act_q, cbr_q;
  logic [ROW_W-1:0] row_q;
  logic             start_evt;
  logic             end_evt;
  logic             cas_early;

  assign cas_early = ~cas_lvl;
  assign start_evt = (state_q == ST_IDLE) && ras_fall;
  assign end_evt   = (state_q == ST_ACTIVE) && ras_rise;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (ras_fall) state_d = ST_ACTIVE;
      ST_ACTIVE: if (ras_rise) state_d = cas_lvl ? ST_IDLE : ST_DRAIN;
      ST_DRAIN:  if (ras_lvl && cas_lvl) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      cbr_q   <= 1'b0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        act_q <= 1'b1;
        cbr_q <= cas_early;
        row_q <= pick_row(cas_early, ref_row, ext_row);
      end else if (end_evt) begin
        act_q <= 1'b0;
      end
    end
  end

  assign row_active = act_q;
  assign cycle_cbr  = cbr_q;
  assign row_addr   = row_q;
  assign inc_req    = end_evt && cbr_q;

  assert_cbr_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !cas_lvl) |=> (cbr_q && row_q == $past(ref_row)));
  assert_pin_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cas_lvl) |=> (!cbr_q && row_q == $past(ext_row)));
  assert_type_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> (!act_q || $stable(cbr_q)));
  assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> (!act_q || $stable(row_q)));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && ras_fall) |=> !act_q);
endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh
  import dram_rfsh_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic [ROW_W-1:0] addr,
  output logic             row_active,
  output logic [ROW_W-1:0] row_addr,
  output logic             cycle_cbr
);
  logic [STB_COUNT-1:0] stb_raw, stb_lvl, stb_fall, stb_rise;
  logic [ROW_W-1:0]     ref_row;
  logic                 inc_req;

  assign stb_raw[STB_RAS] = ras_n;
  assign stb_raw[STB_CAS] = cas_n;

  for (genvar i = 0; i < STB_COUNT; i++) begin : g_stb
    strobe_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (stb_raw[i]),
      .lvl  (stb_lvl[i]),
      .fall (stb_fall[i]),
      .rise (stb_rise[i])
    );
  end

  row_cycle_classifier #(.ROW_W(ROW_W)) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_lvl   (stb_lvl[STB_RAS]),
    .ras_fall  (stb_fall[STB_RAS]),
    .ras_rise  (stb_rise[STB_RAS]),
    .cas_lvl   (stb_lvl[STB_CAS]),
    .ext_row   (addr),
    .ref_row   (ref_row),
    .row_active(row_active),
    .cycle_cbr (cycle_cbr),
    .row_addr  (row_addr),
    .inc_req   (inc_req)
  );

  refresh_row_counter #(.ROW_W(ROW_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (inc_req),
    .cnt  (ref_row)
  );

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_req |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));
  assert_inc_cbr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_req |-> (row_active && cycle_cbr));
  assert_end_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise[STB_RAS] && row_active |=> !row_active);
endmodule

// File: tb/dram_cbr_refresh_bench.sv
module dram_cbr_refresh_bench;
  localparam int ROW_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ras_n = 1'b1;
  logic             cas_n = 1'b1;
  logic [ROW_W-1:0] addr = '0;
  logic             row_active;
  logic [ROW_W-1:0] row_addr;
  logic             cycle_cbr;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cbr_refresh u_dram_cbr_refresh (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr(addr),
    .row_active(row_active), .row_addr(row_addr), .cycle_cbr(cycle_cbr)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk(row_active == 1'b0, "R1 row_active", row_active, 0);
    chk(cycle_cbr == 1'b0, "R1 cycle_cbr", cycle_cbr, 0);
    chk(row_addr == 0, "R1 row_addr", row_addr, 0);
  endtask

  task automatic cbr_cycle(input logic [ROW_W-1:0] junk, input bit full);
    addr = junk;
    cas_n = 1'b0; step(3);
    ras_n = 1'b0; step(2);
    if (full) chk(row_active == 1'b0, "R7 not yet active", row_active, 0);
    step(1);
    if (full) begin
      chk(row_active == 1'b1, "R7 active", row_active, 1);
      chk(cycle_cbr == 1'b1, "R2 cbr flag", cycle_cbr, 1);
      chk(row_addr == exp_cnt[ROW_W-1:0], "R2 counter row", row_addr, exp_cnt);
      addr = ~junk; step(2);
      chk(row_addr == exp_cnt[ROW_W-1:0], "R8 row hold", row_addr, exp_cnt);
    end
    ras_n = 1'b1; step(2);
    if (full) chk(row_active == 1'b1, "R7 still active", row_active, 1);
    step(1);
    if (full) chk(row_active == 1'b0, "R7 released", row_active, 0);
    exp_cnt = (exp_cnt + 1) % 512;
    cas_n = 1'b1; step(3);
  endtask

  task automatic normal_cycle(input logic [ROW_W-1:0] a, input bit access);
    addr = a;
    ras_n = 1'b0; step(3);
    chk(row_active == 1'b1, "R7 active normal", row_active, 1);
    chk(cycle_cbr == 1'b0, "R3 normal flag", cycle_cbr, 0);
    chk(row_addr == a, "R3 pin row", row_addr, a);
    if (access) begin
      cas_n = 1'b0; addr = a ^ 9'h0F3; step(3);
      chk(cycle_cbr == 1'b0, "R10 flag after cas", cycle_cbr, 0);
      chk(row_addr == a, "R10 row after cas", row_addr, a);
      cas_n = 1'b1; step(3);
    end
    ras_n = 1'b1; step(3);
    chk(row_active == 1'b0, "R7 released normal", row_active, 0);
  endtask

  task automatic t_order;
    cas_n = 1'b0; step(3);
    ras_n = 1'b0; step(3);
    chk(row_addr == exp_cnt[ROW_W-1:0], "R2 order row", row_addr, exp_cnt);
    ras_n = 1'b1; step(3);
    exp_cnt = (exp_cnt + 1) % 512;
    ras_n = 1'b0; step(4);
    chk(row_active == 1'b0, "R9 fall ignored", row_active, 0);
    ras_n = 1'b1; step(3);
    cas_n = 1'b1; step(3);
    cbr_cycle(9'h055, 1'b1);
    addr = 9'h101; ras_n = 1'b0; step(3);
    ras_n = 1'b1; cas_n = 1'b0; step(3);
    cas_n = 1'b1; step(3);
    normal_cycle(9'h0AA, 1'b0);
  endtask

  task automatic t_wrap;
    while (exp_cnt != 511) cbr_cycle(9'h000, 1'b0);
    cbr_cycle(9'h1C3, 1'b1);
    chk(exp_cnt == 0, "R5 model wrap", exp_cnt, 0);
    cbr_cycle(9'h1C3, 1'b1);
    chk(exp_cnt == 1, "R5 after wrap", exp_cnt, 1);
  endtask

  initial begin
    step(3);
    t_reset;
    rst_n = 1'b1; step(2);
    t_reset;
    cbr_cycle(9'h1FF, 1'b1);
    cbr_cycle(9'h123, 1'b1);
    normal_cycle(9'h15A, 1'b0);
    normal_cycle(9'h0C7, 1'b1);
    cbr_cycle(9'h000, 1'b1);
    t_order;
    t_wrap;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule